// File: doc/BRIEF.md
# Reload Timer Square-Wave Divider

The block is a reloading up-counter that divides a timer tick into a square wave. The counter runs from a programmable start value up to its all-ones state. On the next counting tick it loads the start value again and flips an output flip-flop. Each flip is one half-period of the square wave. The flip-flop output leaves the block on a shared pin, qualified by that pin's direction and data bits. The pin can therefore be held low, or it can carry the wave.

A counter of width `CNT_W` and start value N gives an output frequency equal to the tick rate divided by 2 × (2^CNT_W − N). With the default width of 16 the divisor is 2 × (65536 − N). A one-clock pulse marks each wrap. The start value can be changed at any time. A new value is used only at the following wrap.

Top module: `pfd_divider`

## Requirements
- R1: The counter advances on a clock edge only when both `tick_i` and `run_i` are 1. Otherwise the count and the wave flip-flop hold.
- R2: When the counter advances from the all-ones value, it loads `preload_i` on that same edge. `ovf_o` is 1 during the following clock cycle, and only after such a wrap.
- R3: The wave flip-flop inverts on every wrap. With the pad enabled, the wave period is 2 × (2^CNT_W − N) advancing ticks. Successive `ovf_o` pulses are 2^CNT_W − N advancing ticks apart.
- R4: A change of `preload_i` does not alter the count in progress. It takes effect at the next wrap.
- R5: While `pin_data_i` is 0, `pad_o` is 0, whether the timer runs or not.
- R6: While the timer is stopped (`run_i` = 0) and `pin_data_i` = 1 with the pin set to output, `pad_o` keeps the last wave level.
- R7: While `pin_out_i` is 0 (pin set to input), `pad_o` is 0. When `pin_out_i` = 1 and `pin_data_i` = 1, `pad_o` equals the wave flip-flop.
- R8: After reset the count is 0, the wave flip-flop is 0, and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer count enable, one clock wide per tick |
| run_i | input | 1 | Timer run bit |
| preload_i | input | CNT_W | Start value N loaded at each wrap |
| pin_data_i | input | 1 | Pin data register bit; 0 forces the pad low |
| pin_out_i | input | 1 | Pin direction; 1 = output, 0 = input |
| pad_o | output | 1 | Pad drive level |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
The bench builds the block with `CNT_W` = 4, so the counter wraps every 1 to 16 ticks. This makes it practical to sweep every preload value and to measure each wrap spacing against 16 − N. A cycle-by-cycle arithmetic model runs beside the design. It also covers gapped ticks, a preload change in the middle of a count, stop-and-hold, and all gating combinations of the pin bits.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned CNT_W_DEF = 16;

  typedef enum logic [1:0] {
    PAD_OFF  = 2'd0,  // pin is an input
    PAD_LOW  = 2'd1,  // output, data bit forces 0
    PAD_WAVE = 2'd2   // output, wave passes
  } pad_sel_e;
endpackage

// File: rtl/pfd_reload_cnt.sv
module pfd_reload_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic             wrap_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign wrap_o = adv_i && (cnt_q == CNT_MAX);
  assign ovf_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap_o;
      if (adv_i) cnt_q <= wrap_o ? preload_i : cnt_q + 1'b1;
    end
  end

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(preload_i)));

  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> $past(adv_i));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pfd_toggle.sv
module pfd_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  output logic wave_o
);
  logic wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wave_q <= 1'b0;
    else if (flip_i) wave_q <= ~wave_q;
  end

  assign wave_o = wave_q;

  assert_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_i |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/pfd_pad_gate.sv
module pfd_pad_gate
  import pfd_pkg::*;
(
  input  logic wave_i,
  input  logic data_i,
  input  logic out_en_i,
  output logic pad_o
);
  pad_sel_e sel;

  always_comb begin
    if (!out_en_i)    sel = PAD_OFF;
    else if (!data_i) sel = PAD_LOW;
    else              sel = PAD_WAVE;
  end

  always_comb begin
    unique case (sel)
      PAD_WAVE: pad_o = wave_i;
      default:  pad_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_force_low_R5: assert (data_i || !pad_o);
    assert_input_low_R7: assert (out_en_i || !pad_o);
  end
endmodule

// File: rtl/pfd_divider.sv
module pfd_divider
  import pfd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             pin_data_i,
  input  logic             pin_out_i,
  output logic             pad_o,
  output logic             ovf_o
);
  logic adv;
  logic wrap;
  logic wave;

  assign adv = tick_i && run_i;

  pfd_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .preload_i (preload_i),
    .wrap_o    (wrap),
    .ovf_o     (ovf_o)
  );

  pfd_toggle u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flip_i (wrap),
    .wave_o (wave)
  );

  pfd_pad_gate u_gate (
    .wave_i   (wave),
    .data_i   (pin_data_i),
    .out_en_i (pin_out_i),
    .pad_o    (pad_o)
  );

  assert_stop_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(wave));

  assert_ovf_wave_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (wave != $past(wave)));
endmodule

// File: tb/pfd_divider_tb.sv
`timescale 1ns/1ps
module pfd_divider_tb;
  localparam int W   = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, run = 1'b0, data = 1'b0, dir = 1'b0;
  logic [W-1:0] pre = '0;
  logic         pad, ovf;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] mcnt;
  logic         mtgl, movf;

  always #4 clk = ~clk;

  pfd_divider #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
    .preload_i(pre), .pin_data_i(data), .pin_out_i(dir),
    .pad_o(pad), .ovf_o(ovf)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic mpad();
    return dir && data && mtgl;
  endfunction

  // one clock: advance the model at posedge, compare at negedge
  task automatic step(string req);
    @(posedge clk);
    movf = 1'b0;
    if (rst_n && tick && run) begin
      if (mcnt == '1) begin
        mcnt = pre; mtgl = ~mtgl; movf = 1'b1;
      end else mcnt = mcnt + 1'b1;
    end
    @(negedge clk);
    chk(ovf == movf, {req, " ovf"}, ovf, movf);
    chk(pad == mpad(), {req, " pad"}, pad, mpad());
  endtask

  task automatic sync(string req);
    for (int i = 0; i < 4 * MOD; i++) begin
      step(req);
      if (ovf) break;
    end
  endtask

  task automatic gap(string req, output int k);
    k = 0;
    for (int i = 0; i < 8 * MOD; i++) begin
      step(req);
      k++;
      if (ovf) break;
    end
  endtask

  initial begin
    int k;
    logic held;
    mcnt = '0; mtgl = 1'b0; movf = 1'b0;
    repeat (3) @(negedge clk);
    chk(pad == 1'b0, "R8 reset pad", pad, 0);
    chk(ovf == 1'b0, "R8 reset ovf", ovf, 0);
    rst_n = 1'b1;
    dir = 1'b1; data = 1'b1; tick = 1'b1;
    repeat (5) step("R8");   // stopped after reset: wave stays 0
    chk(pad == 1'b0, "R8 toggle cleared", pad, 0);

    // R3/R2: all preload values, tick every cycle; first gap from 0 is MOD
    run = 1'b1; pre = '0;
    gap("R8", k);
    chk(k == MOD, "R8 count from zero", k, MOD);
    for (int n = 0; n < MOD; n++) begin
      pre = W'(n);
      sync("R2");
      gap("R3", k);
      chk(k == MOD - n, "R3 wrap spacing", k, MOD - n);
      gap("R3", k);
      chk(k == MOD - n, "R2 reload spacing", k, MOD - n);
    end

    // R1: tick every other cycle doubles spacing
    pre = W'(10);
    sync("R1");
    for (int r = 0; r < 2; r++) begin
      k = 0;
      for (int i = 0; i < 8 * MOD; i++) begin
        tick = ~tick;
        step("R1");
        k++;
        if (ovf) break;
      end
      chk(k == 2 * (MOD - 10), "R1 gapped tick spacing", k, 2 * (MOD - 10));
    end
    tick = 1'b1;

    // R4: preload change mid-count
    pre = '0;
    sync("R4");
    repeat (3) step("R4");
    pre = W'(12);
    gap("R4", k);
    chk(k == MOD - 3, "R4 count in progress kept", k, MOD - 3);
    gap("R4", k);
    chk(k == MOD - 12, "R4 new preload used", k, MOD - 12);

    // R5: data 0 forces low while running and stopped
    pre = W'(13);
    data = 1'b0;
    repeat (20) step("R5");
    chk(pad == 1'b0, "R5 running low", pad, 0);
    run = 1'b0;
    repeat (5) step("R5");
    chk(pad == 1'b0, "R5 stopped low", pad, 0);

    // R6: stopped with data 1 holds last wave level, for both levels
    for (int lv = 0; lv < 2; lv++) begin
      run = 1'b1; data = 1'b1;
      for (int i = 0; i < 4 * MOD; i++) begin
        step("R6");
        if (pad == lv[0] && ovf) break;
      end
      run = 1'b0;
      held = pad;
      chk(held == lv[0], "R6 level reached", held, lv);
      for (int i = 0; i < 20; i++) begin
        step("R6");
        chk(pad == held, "R6 hold", pad, held);
      end
      chk(ovf == 1'b0, "R6 no wrap while stopped", ovf, 0);
    end

    // R7: direction input forces 0, then wave returns
    run = 1'b1; dir = 1'b0;
    repeat (30) step("R7");
    chk(pad == 1'b0, "R7 input low", pad, 0);
    dir = 1'b1;
    repeat (30) step("R7");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule